// File: doc/BRIEF.md
# Double-Buffered Crosspoint Routing Controller

This block keeps the routing state of a 34-by-34 digital crosspoint in which every output lane picks exactly one input lane. Each output owns two selection registers: a staging register that takes new routing writes and a live register that actually steers the output multiplexer. Software reaches the block over a small synchronous register port with an 8-bit address, 8-bit write data and a registered 8-bit read data bus.

A mode register picks how staged selections become live. In pass-through mode every routing write lands in both registers at once. In the two deferred modes a routing write touches only the staging register; all staged values are then copied into the live registers in one cycle, either when software writes to the commit register or when an external active-low commit strobe falls. The strobe is asynchronous and is synchronized inside the block. The live selections are exposed on a flat bus and drive one 34-to-1 multiplexer per output, so the routing can be checked directly at the lane pins.

The register port and the strobe are plain control pins with no handshake: a request is taken in the cycle where `cfg_en` is high, and every request is accepted.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: After reset the mode reads 00h (pass-through) and every output's staging and live selections are 0, so every output lane carries input lane 0.
- R2: In pass-through mode a write to address 00h–21h with data below 34 sets both registers of output number `cfg_addr`; the live selection and `lane_out` change after that same clock edge.
- R3: In software-commit mode (01h) or strobe-commit mode (02h) a routing write changes only the staging register; live selections, readback and `lane_out` stay as they were.
- R4: In software-commit mode a write of any data to address E8h copies all 34 staging registers into the live registers on the same edge.
- R5: In strobe-commit mode a falling edge on `commit_strobe_n` copies all staging registers into the live registers at the third rising clock edge after the fall (two synchronizer stages plus the commit edge); the rising edge of the strobe copies nothing.
- R6: A falling strobe edge has no effect outside strobe-commit mode, and a write to E8h has no effect outside software-commit mode.
- R7: A routing write with data of 34 or more leaves both registers of that output unchanged.
- R8: A write to E7h with data 00h, 01h or 02h sets the mode; any other data leaves the mode unchanged.
- R9: A read (`cfg_en` high, `cfg_wr` low) returns on `cfg_rdata` after the next edge: the live selection zero-extended for 00h–21h, the mode for E7h, and 00h for any other address.
- R10: `lane_out[o]` equals `lane_in[s]` where `s` is the live selection of output `o`, and `live_sel` bits `[6*o+5:6*o]` hold that selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Register access request this cycle |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| commit_strobe_n | input | 1 | Asynchronous active-low commit strobe |
| lane_in | input | 34 | Crosspoint input lanes |
| lane_out | output | 34 | Crosspoint output lanes |
| live_sel | output | 204 | Live selection of every output, 6 bits each |

## Verification
The bench goes after the split between staging and live state: a design that wrote routing data straight to the live registers in a deferred mode would change the lanes before the commit, and one that copied only the addressed output would leave most of a full 34-output commit unapplied. It drives strobe edges and E8h writes in the wrong modes, where a design with a loose mode decode would commit early. It writes out-of-range selections and illegal mode codes, which a design that truncated the data would accept as aliases, and it reads unmapped addresses and the commit address, which must return zero.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_SW   = 2'd1,
    MODE_HW   = 2'd2
  } upd_mode_e;

  localparam logic [7:0] ADDR_MODE   = 8'hE7;
  localparam logic [7:0] ADDR_COMMIT = 8'hE8;
endpackage

// File: rtl/xbar_strobe_sync.sv
module xbar_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n_async,
  output logic fall_pulse
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= strobe_n_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall_pulse = prev_q & ~sync_q;
endmodule

// File: rtl/xbar_route_bank.sv
module xbar_route_bank #(
  parameter int N_PORTS = 34,
  parameter int SEL_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_idx,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic                       wr_through,
  input  logic                       commit,
  output logic [N_PORTS*SEL_W-1:0]   stage_flat,
  output logic [N_PORTS*SEL_W-1:0]   live_flat
);
  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    logic [SEL_W-1:0] stage_q, live_q;
    logic             hit;

    assign hit = wr_en && (wr_idx == SEL_W'(o));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q <= '0;
        live_q  <= '0;
      end else begin
        if (hit) stage_q <= wr_sel;
        if (hit && wr_through) live_q <= wr_sel;
        else if (commit)       live_q <= stage_q;
      end
    end

    assign stage_flat[o*SEL_W +: SEL_W] = stage_q;
    assign live_flat[o*SEL_W +: SEL_W]  = live_q;
  end
endmodule

// File: rtl/xbar_lane_mux.sv
module xbar_lane_mux #(
  parameter int N_PORTS = 34,
  parameter int SEL_W   = 6
) (
  input  logic [N_PORTS*SEL_W-1:0] live_flat,
  input  logic [N_PORTS-1:0]       lane_in,
  output logic [N_PORTS-1:0]       lane_out
);
  for (genvar o = 0; o < N_PORTS; o++) begin : g_mux
    logic [SEL_W-1:0] sel;
    assign sel = live_flat[o*SEL_W +: SEL_W];

    always_comb begin
      lane_out[o] = 1'b0;
      for (int i = 0; i < N_PORTS; i++) begin
        if (sel == SEL_W'(i)) lane_out[o] = lane_in[i];
      end
    end
  end
endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl #(
  parameter int N_PORTS = 34,
  parameter int SEL_W   = $clog2(N_PORTS),
  parameter int REG_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_en,
  input  logic                       cfg_wr,
  input  logic [REG_W-1:0]           cfg_addr,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [REG_W-1:0]           cfg_rdata,
  input  logic                       commit_strobe_n,
  input  logic [N_PORTS-1:0]         lane_in,
  output logic [N_PORTS-1:0]         lane_out,
  output logic [N_PORTS*SEL_W-1:0]   live_sel
);
  import xbar_cfg_pkg::*;

  localparam int TOTAL_W = N_PORTS * SEL_W;

  upd_mode_e            mode_q;
  logic                 wr_req, rd_req, route_addr, route_wr;
  logic                 sw_go, hw_go, commit_go, strobe_fall;
  logic [SEL_W-1:0]     idx;
  logic [TOTAL_W-1:0]   stage_flat, live_flat;
  logic [REG_W-1:0]     rd_next;

  assign wr_req     = cfg_en && cfg_wr;
  assign rd_req     = cfg_en && !cfg_wr;
  assign idx        = cfg_addr[SEL_W-1:0];
  assign route_addr = (int'(cfg_addr) < N_PORTS);
  assign route_wr   = wr_req && route_addr && (int'(cfg_wdata) < N_PORTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_PASS;
    end else if (wr_req && cfg_addr == ADDR_MODE && cfg_wdata <= REG_W'(MODE_HW)) begin
      mode_q <= upd_mode_e'(cfg_wdata[1:0]);
    end
  end

  xbar_strobe_sync u_sync (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe_n_async (commit_strobe_n),
    .fall_pulse     (strobe_fall)
  );

  assign sw_go     = wr_req && cfg_addr == ADDR_COMMIT && mode_q == MODE_SW;
  assign hw_go     = strobe_fall && mode_q == MODE_HW;
  assign commit_go = sw_go || hw_go;

  xbar_route_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (route_wr),
    .wr_idx     (idx),
    .wr_sel     (cfg_wdata[SEL_W-1:0]),
    .wr_through (mode_q == MODE_PASS),
    .commit     (commit_go),
    .stage_flat (stage_flat),
    .live_flat  (live_flat)
  );

  xbar_lane_mux #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_mux (
    .live_flat (live_flat),
    .lane_in   (lane_in),
    .lane_out  (lane_out)
  );

  always_comb begin
    rd_next = '0;
    if (route_addr) begin
      for (int o = 0; o < N_PORTS; o++) begin
        if (idx == SEL_W'(o)) rd_next[SEL_W-1:0] = live_flat[o*SEL_W +: SEL_W];
      end
    end else if (cfg_addr == ADDR_MODE) begin
      rd_next[1:0] = mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (rd_req) cfg_rdata <= rd_next;
  end

  assign live_sel = live_flat;

  logic unused_stage;
  assign unused_stage = ^stage_flat;
endmodule

// File: rtl/xbar_cfg_checker.sv
module xbar_cfg_checker #(
  parameter int N_PORTS = 34,
  parameter int SEL_W   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_en,
  input logic                     cfg_wr,
  input logic [7:0]               cfg_addr,
  input logic [7:0]               cfg_wdata,
  input logic [7:0]               cfg_rdata,
  input logic [1:0]               mode,
  input logic                     commit,
  input logic [N_PORTS*SEL_W-1:0] live_flat
);
  AST_PASS_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_wr && mode == 2'd0 && int'(cfg_addr) < N_PORTS && int'(cfg_wdata) < N_PORTS)
    |=> live_flat[$past(cfg_addr[SEL_W-1:0]) * SEL_W +: SEL_W] == $past(cfg_wdata[SEL_W-1:0])); // R2

  AST_LIVE_HELD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg_en && cfg_wr && mode == 2'd0) && !commit) |=> $stable(live_flat)); // R3

  AST_BAD_SEL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_wr && int'(cfg_addr) < N_PORTS && int'(cfg_wdata) >= N_PORTS && !commit)
    |=> $stable(live_flat)); // R7

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3); // R8

  AST_MODE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_wr && cfg_addr == 8'hE7) |=> cfg_rdata == {6'd0, $past(mode)}); // R9
endmodule

bind xbar_cfg_ctrl xbar_cfg_checker #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .mode      (mode_q),
  .commit    (commit_go),
  .live_flat (live_flat)
);

// File: tb/xbar_cfg_ctrl_bench.sv
module xbar_cfg_ctrl_bench;
  localparam int N = 34;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0, cfg_wr = 1'b0;
  logic [7:0]    cfg_addr = '0, cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          commit_strobe_n = 1'b1;
  logic [N-1:0]  lane_in = '0;
  logic [N-1:0]  lane_out;
  logic [N*SW-1:0] live_sel;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int exp_live [N];
  int exp_stage[N];
  int exp_mode;

  always #2 clk = ~clk;

  xbar_cfg_ctrl u_xbar_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .commit_strobe_n(commit_strobe_n), .lane_in(lane_in),
    .lane_out(lane_out), .live_sel(live_sel)
  );

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int addr, input int data);
    @(negedge clk);
    cfg_en = 1'b1; cfg_wr = 1'b1; cfg_addr = 8'(addr); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_en = 1'b0; cfg_wr = 1'b0;
    if (addr < N && data < N) begin
      exp_stage[addr] = data;
      if (exp_mode == 0) exp_live[addr] = data;
    end else if (addr == 'hE7 && data <= 2) begin
      exp_mode = data;
    end else if (addr == 'hE8 && exp_mode == 1) begin
      for (int o = 0; o < N; o++) exp_live[o] = exp_stage[o];
    end
  endtask

  task automatic reg_read(input int addr, input int exp, input string req);
    @(negedge clk);
    cfg_en = 1'b1; cfg_wr = 1'b0; cfg_addr = 8'(addr);
    @(negedge clk);
    cfg_en = 1'b0;
    check(req, cfg_rdata, exp);
  endtask

  task automatic check_lanes(input string req);
    logic [N-1:0] exp_out;
    logic [N*SW-1:0] exp_sel;
    for (int p = 0; p < 2; p++) begin
      lane_in = (p == 0) ? 34'h2_D5A3_96C1 : 34'h1_2A5C_693E;
      #1;
      for (int o = 0; o < N; o++) begin
        exp_out[o] = lane_in[exp_live[o]];
        exp_sel[o*SW +: SW] = SW'(exp_live[o]);
      end
      check(req, lane_out, exp_out);
    end
    check("R10 live_sel", live_sel, exp_sel);
  endtask

  task automatic strobe_fall_and_wait();
    @(negedge clk);
    commit_strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    if (exp_mode == 2) for (int o = 0; o < N; o++) exp_live[o] = exp_stage[o];
  endtask

  task automatic strobe_rise_and_wait();
    @(negedge clk);
    commit_strobe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    reg_read('hE7, 0, "R1 mode");
    reg_read(5, 0, "R1 sel");
    check_lanes("R1 lanes");
  endtask

  task automatic t_pass_through();
    reg_write(3, 17);
    reg_write(33, 33);
    reg_write(0, 5);
    reg_read(3, 17, "R2 out3");
    reg_read(33, 33, "R2 out33");
    check_lanes("R2 lanes");
  endtask

  task automatic t_bad_data();
    reg_write(3, 34);
    reg_write(3, 255);
    reg_read(3, 17, "R7 out3");
    check_lanes("R7 lanes");
  endtask

  task automatic t_mode_reg();
    reg_write('hE7, 5);
    reg_read('hE7, 0, "R8 illegal");
    reg_write('hE7, 3);
    reg_read('hE7, 0, "R8 code3");
    reg_write('hE7, 1);
    reg_read('hE7, 1, "R8 sw");
  endtask

  task automatic t_soft_commit();
    reg_write(3, 9);
    reg_write(10, 20);
    reg_read(3, 17, "R3 staged only");
    check_lanes("R3 lanes");
    strobe_fall_and_wait();
    strobe_rise_and_wait();
    reg_read(3, 17, "R6 strobe in sw");
    reg_write('hE8, 'hA5);
    reg_read(3, 9, "R4 out3");
    reg_read(10, 20, "R4 out10");
    check_lanes("R4 lanes");
  endtask

  task automatic t_hw_commit();
    reg_write('hE7, 2);
    reg_read('hE7, 2, "R8 hw");
    reg_write(7, 30);
    reg_write(3, 1);
    reg_write('hE8, 0);
    reg_read(7, 0, "R6 E8 in hw");
    strobe_fall_and_wait();
    reg_read(7, 30, "R5 out7");
    reg_read(3, 1, "R5 out3");
    reg_write(7, 2);
    strobe_rise_and_wait();
    reg_read(7, 30, "R5 rising edge");
    for (int o = 0; o < N; o++) reg_write(o, (o * 7 + 3) % N);
    check_lanes("R3 hw staged");
    strobe_fall_and_wait();
    check_lanes("R5 full commit");
    strobe_rise_and_wait();
  endtask

  task automatic t_back_to_pass();
    reg_write('hE7, 0);
    reg_write('hE8, 0);
    reg_write(0, 12);
    reg_read(0, 12, "R2 after mode change");
    strobe_fall_and_wait();
    strobe_rise_and_wait();
    check_lanes("R6 strobe in pass");
    reg_read('h50, 0, "R9 unmapped");
    reg_read('hE8, 0, "R9 commit addr");
    reg_read(33, (33 * 7 + 3) % N, "R9 out33");
  endtask

  initial begin
    exp_mode = 0;
    for (int o = 0; o < N; o++) begin
      exp_live[o] = 0;
      exp_stage[o] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass_through();
    t_bad_data();
    t_mode_reg();
    t_soft_commit();
    t_hw_commit();
    t_back_to_pass();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule